// File: doc/BRIEF.md
# Per-Master Ready Return Network

This block forms the readiness half of the return path in a small bus matrix built on the AHB protocol. It serves two initiators and three targets by default. Each target reports its own completion flag. Each initiator needs one ready input that tells it whether its current data phase has finished.

For every initiator, the block keeps a data-phase target register. The register loads the decoded target index and a valid bit, and it loads only when that initiator's ready is high. The initiator's ready is then taken from the completion flag of that recorded target. When no target is recorded, the ready is forced high, so an idle initiator can always issue its next address. The same value is also returned to the target as that target's ready input. A wait state therefore stalls both ends in the same cycle, and the target samples its next address phase only when the initiator advances.

Address decoding, arbitration and the read-data and response multiplexers are outside this block. It receives each initiator's decoded one-hot target select, together with a transfer-valid bit. The transfer-valid bit is high for NONSEQ and SEQ and low for IDLE and BUSY.

Top module: `rdy_return_net`

## Requirements
- R1: While reset is active, and in the first cycle after it, every initiator ready and every target ready input is high, and no data-phase target is recorded.
- R2: An initiator with a recorded target sees exactly that target's completion flag on its ready. The completion flags of all other targets have no effect on it.
- R3: An initiator's target register changes only on a rising edge where that initiator's ready is high. During a wait state, a new select on the input does not redirect the ready.
- R4: If the transfer-valid bit is low (IDLE or BUSY) on an edge where the initiator's ready is high, the recorded target is cleared. This holds whatever select is present.
- R5: An initiator with no recorded target sees ready high, whatever the targets drive.
- R6: A target in data phase with an initiator receives, on its ready input, the same value that initiator receives, in the same cycle.
- R7: A target that no initiator has recorded as its data-phase target receives a ready input of 1.
- R8: A target holding its completion flag low does not stall an initiator whose data phase is with a different target.
- R9: A target that inserts one wait state drives its flag low and then high. The initiator's ready shows the same low-then-high pattern in the same cycles, with no added latency.
- R10: A transfer with the valid bit high but an all-zero select (a decode that hits no target) records no target. The next data phase therefore sees ready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_slv_sel | input | NUM_MST*NUM_SLV | One-hot decoded target per initiator; initiator m uses bits [m*NUM_SLV +: NUM_SLV], bit s selects target s |
| m_xfer | input | NUM_MST | Transfer valid per initiator (1 = NONSEQ/SEQ, 0 = IDLE/BUSY) |
| s_rdy_out | input | NUM_SLV | Completion flag driven by each target |
| m_rdy | output | NUM_MST | Ready returned to each initiator |
| s_rdy_in | output | NUM_SLV | Ready returned to each target |

## Verification
The assertions assume that each initiator's select has at most one bit set. They also assume that arbitration never leaves two initiators in data phase with the same target. The ownership check flags any breach of that second assumption. The stimulus respects both assumptions: before an initiator may load a new target, the bench looks at the other initiator's current target, or at the target it is about to record, and replaces a clashing pick with a no-hit select. The sweep makes target 0 always ready, target 1 random, and target 2 mostly waiting. This produces long concurrent stalls next to zero-wait traffic.

// File: rtl/rdy_net_pkg.sv
`timescale 1ns/1ps
package rdy_net_pkg;

   // Storage style of the per-initiator data-phase target register
   typedef enum logic {
      TGT_INDEX  = 1'b0,
      TGT_ONEHOT = 1'b1
   } tgt_style_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rdy_oh_enc.sv
`timescale 1ns/1ps
module rdy_oh_enc #(
   parameter int unsigned N = 3,
   parameter int unsigned W = 2
) (
   input  logic [N-1:0] oh,
   output logic [W-1:0] idx
);

   // OR-based encoder: exact for one-hot or zero input
   always_comb begin
      idx = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (oh[i]) idx = idx | W'(i);
      end
   end

endmodule

// File: rtl/rdy_tgt_reg.sv
`timescale 1ns/1ps
module rdy_tgt_reg
   import rdy_net_pkg::*;
#(
   parameter int unsigned NUM_SLV = 3,
   parameter tgt_style_e  STYLE   = TGT_ONEHOT,
   localparam int unsigned IDX_W  = idx_bits(NUM_SLV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SLV-1:0] sel,
   input  logic               xfer,
   input  logic               rdy,
   output logic               tgt_vld,
   output logic [IDX_W-1:0]   tgt_idx,
   output logic [NUM_SLV-1:0] tgt_oh
);

   logic hit;
   assign hit = xfer & (|sel);

   if (STYLE == TGT_ONEHOT) begin : g_onehot
      logic [NUM_SLV-1:0] oh_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   oh_q <= '0;
         else if (rdy) oh_q <= hit ? sel : '0;
      end

      rdy_oh_enc #(.N(NUM_SLV), .W(IDX_W)) u_enc (
         .oh  (oh_q),
         .idx (tgt_idx)
      );

      assign tgt_oh  = oh_q;
      assign tgt_vld = |oh_q;
   end else begin : g_index
      logic [IDX_W-1:0] idx_q;
      logic             vld_q;
      logic [IDX_W-1:0] sel_idx;

      rdy_oh_enc #(.N(NUM_SLV), .W(IDX_W)) u_enc (
         .oh  (sel),
         .idx (sel_idx)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            idx_q <= '0;
         end else if (rdy) begin
            vld_q <= hit;
            idx_q <= hit ? sel_idx : '0;
         end
      end

      always_comb begin
         for (int i = 0; i < int'(NUM_SLV); i++) begin
            tgt_oh[i] = vld_q && (idx_q == IDX_W'(i));
         end
      end

      assign tgt_idx = idx_q;
      assign tgt_vld = vld_q;
   end

   AST_TGT_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> $stable(tgt_oh)); // R3
   AST_TGT_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !xfer) |=> !tgt_vld); // R4
   AST_TGT_NOHIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && sel == '0) |=> !tgt_vld); // R10
   AST_TGT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_oh)); // R2

endmodule

// File: rtl/rdy_mst_mux.sv
`timescale 1ns/1ps
module rdy_mst_mux
   import rdy_net_pkg::*;
#(
   parameter int unsigned NUM_SLV = 3,
   parameter tgt_style_e  STYLE   = TGT_ONEHOT,
   localparam int unsigned IDX_W  = idx_bits(NUM_SLV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tgt_vld,
   input  logic [IDX_W-1:0]   tgt_idx,
   input  logic [NUM_SLV-1:0] tgt_oh,
   input  logic [NUM_SLV-1:0] s_rdy_out,
   output logic               rdy
);

   if (STYLE == TGT_ONEHOT) begin : g_andor
      // AND-OR select; an empty vector falls back to ready
      assign rdy = ~tgt_vld | (|(tgt_oh & s_rdy_out));
   end else begin : g_index
      assign rdy = tgt_vld ? s_rdy_out[tgt_idx] : 1'b1;
   end

   AST_IDLE_MASTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_vld |-> rdy); // R5
   AST_TGT_FORMS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_vld |-> tgt_oh[tgt_idx]); // R2

endmodule

// File: rtl/rdy_slv_fb.sv
`timescale 1ns/1ps
module rdy_slv_fb #(
   parameter int unsigned NUM_MST = 2,
   parameter int unsigned NUM_SLV = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_MST*NUM_SLV-1:0] tgt_oh_all,
   input  logic [NUM_MST-1:0]         m_rdy,
   output logic [NUM_SLV-1:0]         s_rdy_in
);

   for (genvar s = 0; s < int'(NUM_SLV); s++) begin : g_slv
      logic [NUM_MST-1:0] owner;
      logic               acc;

      always_comb begin
         acc = 1'b1;
         for (int m = 0; m < int'(NUM_MST); m++) begin
            owner[m] = tgt_oh_all[m*NUM_SLV + s];
            acc      = acc & (~owner[m] | m_rdy[m]);
         end
      end

      assign s_rdy_in[s] = acc;

      AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(owner) <= 1); // R6
      AST_FREE_SLV_READY: assert property (@(posedge clk) disable iff (!rst_n)
         (owner == '0) |-> s_rdy_in[s]); // R7
   end

endmodule

// File: rtl/rdy_return_net.sv
`timescale 1ns/1ps
module rdy_return_net
   import rdy_net_pkg::*;
#(
   parameter int unsigned NUM_MST = 2,
   parameter int unsigned NUM_SLV = 3,
   parameter tgt_style_e  STYLE   = TGT_ONEHOT
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_MST*NUM_SLV-1:0] m_slv_sel,
   input  logic [NUM_MST-1:0]         m_xfer,
   input  logic [NUM_SLV-1:0]         s_rdy_out,
   output logic [NUM_MST-1:0]         m_rdy,
   output logic [NUM_SLV-1:0]         s_rdy_in
);

   localparam int unsigned IDX_W = idx_bits(NUM_SLV);

   if (NUM_MST < 1)  begin : g_bad_mst  $error("NUM_MST must be at least 1");  end
   if (NUM_SLV < 1)  begin : g_bad_slv  $error("NUM_SLV must be at least 1");  end
   if (NUM_SLV > 64) begin : g_big_slv  $error("NUM_SLV above 64 unsupported"); end

   logic [NUM_MST*NUM_SLV-1:0] tgt_oh_all;
   logic [NUM_MST-1:0]         tgt_vld;
   logic [NUM_MST*IDX_W-1:0]   tgt_idx_all;

   for (genvar m = 0; m < int'(NUM_MST); m++) begin : g_mst
      rdy_tgt_reg #(.NUM_SLV(NUM_SLV), .STYLE(STYLE)) u_tgt (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (m_slv_sel[m*NUM_SLV +: NUM_SLV]),
         .xfer    (m_xfer[m]),
         .rdy     (m_rdy[m]),
         .tgt_vld (tgt_vld[m]),
         .tgt_idx (tgt_idx_all[m*IDX_W +: IDX_W]),
         .tgt_oh  (tgt_oh_all[m*NUM_SLV +: NUM_SLV])
      );

      rdy_mst_mux #(.NUM_SLV(NUM_SLV), .STYLE(STYLE)) u_mux (
         .clk       (clk),
         .rst_n     (rst_n),
         .tgt_vld   (tgt_vld[m]),
         .tgt_idx   (tgt_idx_all[m*IDX_W +: IDX_W]),
         .tgt_oh    (tgt_oh_all[m*NUM_SLV +: NUM_SLV]),
         .s_rdy_out (s_rdy_out),
         .rdy       (m_rdy[m])
      );

      AST_MST_TRACKS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
         tgt_vld[m] |-> (m_rdy[m] == s_rdy_out[tgt_idx_all[m*IDX_W +: IDX_W]])); // R2

      for (genvar s = 0; s < int'(NUM_SLV); s++) begin : g_pair
         AST_SHARED_READY: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_oh_all[m*NUM_SLV + s] |-> (s_rdy_in[s] == m_rdy[m])); // R6
      end
   end

   rdy_slv_fb #(.NUM_MST(NUM_MST), .NUM_SLV(NUM_SLV)) u_fb (
      .clk        (clk),
      .rst_n      (rst_n),
      .tgt_oh_all (tgt_oh_all),
      .m_rdy      (m_rdy),
      .s_rdy_in   (s_rdy_in)
   );

   AST_RESET_ALL_READY: assert property (@(posedge clk)
      !rst_n |-> (&m_rdy && &s_rdy_in)); // R1

endmodule

// File: tb/rdy_return_net_tb_top.sv
`timescale 1ns/1ps
module rdy_return_net_tb_top;

   localparam int NM = 2;
   localparam int NS = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NM*NS-1:0] m_slv_sel = '0;
   logic [NM-1:0]  m_xfer = '0;
   logic [NS-1:0]  s_rdy_out = '1;
   logic [NM-1:0]  m_rdy;
   logic [NS-1:0]  s_rdy_in;

   int tests = 0;
   int fails = 0;
   int tgt [NM];
   int cs  [NM];
   bit cx  [NM];
   int unsigned seed = 32'h1234_5678;

   always #10 clk = ~clk;

   rdy_return_net #(.NUM_MST(NM), .NUM_SLV(NS)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .m_slv_sel (m_slv_sel),
      .m_xfer    (m_xfer),
      .s_rdy_out (s_rdy_out),
      .m_rdy     (m_rdy),
      .s_rdy_in  (s_rdy_in)
   );

   function automatic int unsigned rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   function automatic logic exp_m(int m);
      return (tgt[m] >= 0) ? s_rdy_out[tgt[m]] : 1'b1;
   endfunction

   function automatic int owner_of(int s);
      for (int m = 0; m < NM; m++) if (tgt[m] == s) return m;
      return -1;
   endfunction

   function automatic logic exp_s(int s);
      int o;
      o = owner_of(s);
      return (o >= 0) ? exp_m(o) : 1'b1;
   endfunction

   task automatic chk(string tag, logic act, logic exp, string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic drive(int s0, bit x0, int s1, bit x1, logic [NS-1:0] so);
      @(negedge clk);
      m_slv_sel = '0;
      if (s0 >= 0) m_slv_sel[s0] = 1'b1;
      if (s1 >= 0) m_slv_sel[NS + s1] = 1'b1;
      m_xfer    = {x1, x0};
      s_rdy_out = so;
      cs[0] = s0; cs[1] = s1;
      cx[0] = x0; cx[1] = x1;
      #2;
   endtask

   task automatic check_all();
      for (int m = 0; m < NM; m++)
         chk((tgt[m] >= 0) ? "R2" : "R5", m_rdy[m], exp_m(m), $sformatf("m_rdy[%0d]", m));
      for (int s = 0; s < NS; s++)
         chk((owner_of(s) >= 0) ? "R6" : "R7", s_rdy_in[s], exp_s(s), $sformatf("s_rdy_in[%0d]", s));
   endtask

   task automatic adv();
      int nx [NM];
      for (int m = 0; m < NM; m++)
         nx[m] = exp_m(m) ? ((cx[m] && cs[m] >= 0) ? cs[m] : -1) : tgt[m];
      @(posedge clk);
      for (int m = 0; m < NM; m++) tgt[m] = nx[m];
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int m = 0; m < NM; m++) begin tgt[m] = -1; cs[m] = -1; cx[m] = 0; end
      // R1: reset state with hostile inputs
      m_slv_sel = 6'b010_001; m_xfer = 2'b11; s_rdy_out = 3'b000;
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      for (int m = 0; m < NM; m++) chk("R1", m_rdy[m], 1'b1, "m_rdy in reset");
      for (int s = 0; s < NS; s++) chk("R1", s_rdy_in[s], 1'b1, "s_rdy_in in reset");
      rst_n = 1'b1;
      m_slv_sel = '0; m_xfer = '0; s_rdy_out = '1;
      @(posedge clk);
      drive(-1, 0, -1, 0, 3'b000);
      for (int m = 0; m < NM; m++) chk("R1", m_rdy[m], 1'b1, "m_rdy after reset");
      adv();

      // R9: one wait state on target 1
      drive(1, 1, -1, 0, 3'b111); check_all(); adv();
      drive(-1, 0, -1, 0, 3'b101); check_all();
      chk("R9", m_rdy[0], 1'b0, "wait low");
      chk("R6", s_rdy_in[1], 1'b0, "target sees wait");
      adv();
      drive(-1, 0, -1, 0, 3'b111); check_all();
      chk("R9", m_rdy[0], 1'b1, "wait released");
      adv();

      // R8 and R3: initiator 0 stuck on slow target 2, initiator 1 streams
      drive(2, 1, 0, 1, 3'b111); check_all(); adv();
      for (int i = 0; i < 4; i++) begin
         drive(0, 1, (i % 2 == 0) ? 1 : 0, 1, 3'b011); check_all();
         chk("R8", m_rdy[1], 1'b1, "fast initiator not stalled");
         chk("R3", m_rdy[0], 1'b0, "held on slow target");
         adv();
      end
      drive(-1, 0, -1, 0, 3'b111); check_all();
      chk("R3", m_rdy[0], 1'b1, "slow target done");
      adv();

      // R4: IDLE with a select present records nothing
      drive(1, 0, -1, 0, 3'b111); check_all(); adv();
      drive(-1, 0, -1, 0, 3'b000); check_all();
      chk("R4", m_rdy[0], 1'b1, "idle after IDLE");
      chk("R7", s_rdy_in[1], 1'b1, "unowned target");
      adv();

      // R10: valid transfer, decode miss
      drive(-1, 1, -1, 0, 3'b111); check_all(); adv();
      drive(-1, 0, -1, 0, 3'b000); check_all();
      chk("R10", m_rdy[0], 1'b1, "no-hit data phase");
      adv();

      // back-to-back switch between targets
      drive(1, 1, -1, 0, 3'b111); check_all(); adv();
      drive(0, 1, -1, 0, 3'b101); check_all(); adv();
      drive(0, 1, -1, 0, 3'b111); check_all(); adv();
      drive(-1, 0, -1, 0, 3'b110); check_all();
      chk("R2", m_rdy[0], 1'b0, "follows new target 0");
      chk("R2", s_rdy_in[1], 1'b1, "old target released");
      adv();
      drive(-1, 0, -1, 0, 3'b111); check_all(); adv();

      // sweep
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         int c0, c1, post0;
         bit x0, x1, l0, l1;
         logic [NS-1:0] so;
         r  = rnd();
         so = {(r[1:0] == 2'b00), r[2], 1'b1};
         // readiness with this cycle's flags decides who loads
         l0 = (tgt[0] >= 0) ? so[tgt[0]] : 1'b1;
         l1 = (tgt[1] >= 0) ? so[tgt[1]] : 1'b1;
         c0 = int'(r[5:4]) - 1;
         c1 = int'(r[7:6]) - 1;
         x0 = (r[9:8] != 2'b00);
         x1 = (r[11:10] != 2'b00);
         if (!l1 && c0 == tgt[1]) c0 = -1;
         post0 = l0 ? ((x0 && c0 >= 0) ? c0 : -1) : tgt[0];
         if (c1 >= 0 && c1 == post0) c1 = -1;
         drive(c0, x0, c1, x1, so);
         check_all();
         adv();
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule